// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address when the translation cache has missed. It divides the address into three fields: a 10-bit outer index in bits 31:22, a 10-bit inner index in bits 21:12 and a 12-bit byte offset in bits 11:0. The walk then makes two dependent reads over a request/response memory port. The first read fetches the outer entry from the table that the root base points at. The frame number in that entry names the 4 KB page holding the relevant slice of the inner table. The second read fetches the leaf entry from that page. The leaf frame number, placed above the untouched offset, forms the physical address.

Every table entry is 32 bits wide: bit 31 is the valid flag, bit 30 grants write permission, bits 29:20 are spare and bits 19:0 hold a frame number. A clear valid flag at either level stops the walk with a fault, and the fault carries the level at which it was found. A write request whose leaf entry lacks write permission also faults at level 2. The walker handles one request at a time. It reports each result with a one-cycle pulse and is ready for the next request in the cycle that follows.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0.
- R2: A request is taken only in a cycle where req_ready is 1. req_ready stays 0 from the cycle after acceptance until the result pulse has ended, and a request presented in that time has no effect.
- R3: The first table read has address root_base + 4 * vaddr[31:22]. root_base is sampled in the acceptance cycle, so a later change does not affect the walk in progress.
- R4: Once mem_req_valid is 1, it and mem_req_addr stay unchanged until a cycle in which mem_req_ready is 1.
- R5: If the outer entry has bit 31 clear, the walk ends with rsp_fault = 1 and rsp_fault_level = 1, and no second read is issued.
- R6: The second table read has address {outer entry bits 19:0, vaddr[21:12], 2'b00}. The write-permission bit of the outer entry has no effect.
- R7: If the leaf entry has bit 31 clear, the walk ends with rsp_fault = 1 and rsp_fault_level = 2.
- R8: A write request (req_write = 1) whose valid leaf entry has bit 30 clear faults with rsp_fault_level = 2. A read request with that same leaf entry succeeds.
- R9: A successful walk returns rsp_paddr = {leaf entry bits 19:0, vaddr[11:0]} with rsp_fault = 0 and rsp_fault_level = 0. On a fault, rsp_paddr is 0.
- R10: rsp_valid is high for exactly one cycle per accepted request. It rises in the cycle after the deciding read response, and req_ready is 1 again in the following cycle.
- R11: mem_rsp_valid has no effect unless a table read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| root_base | input | 32 | Byte address of the outer table |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read this cycle |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Table entry returned by memory |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_level | output | 2 | Level that faulted: 1 outer, 2 inner, 0 none |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
A wrong internal state appears at the ports within the cycle it occurs. A walker that takes the wrong branch either puts a read on the port when none is expected, or shows the wrong address, or drops a read that should have been issued. A corrupted latched address or root shows up in the very next table address, well before the result pulse. Errors in the frame captured from the outer entry first appear in the inner read address. Errors in the leaf frame, the offset or the fault level first appear in the single result cycle. For this reason every output is compared against a behavioural model on every clock, and varied memory stalls and latencies shift each transition to different cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int unsigned PTW_VA_W      = 32;
  localparam int unsigned PTW_OFF_W     = 12;
  localparam int unsigned PTW_IDX_W     = 10;
  localparam int unsigned PTW_PTE_W     = 32;
  localparam int unsigned PTW_PTE_LG    = 2;
  localparam int unsigned PTW_FRAME_W   = PTW_VA_W - PTW_OFF_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_L1,
    ST_WAIT_L1,
    ST_READ_L2,
    ST_WAIT_L2,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  localparam logic [1:0] LVL_NONE  = 2'd0;
  localparam logic [1:0] LVL_OUTER = 2'd1;
  localparam logic [1:0] LVL_INNER = 2'd2;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VA_W   = ptw_pkg::PTW_VA_W,
  parameter int unsigned OFF_W  = ptw_pkg::PTW_OFF_W,
  parameter int unsigned IDX_W  = ptw_pkg::PTW_IDX_W,
  parameter int unsigned PTE_LG = ptw_pkg::PTW_PTE_LG,
  localparam int unsigned FRAME_W = VA_W - OFF_W
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [VA_W-1:0]    root,
  input  logic [FRAME_W-1:0] outer_frame,
  input  logic               sel_inner,
  output logic [VA_W-1:0]    tbl_addr
);

  // Index fields: outer index at the top, inner index just above the offset.
  logic [IDX_W-1:0] outer_idx;
  logic [IDX_W-1:0] inner_idx;
  logic [VA_W-1:0]  outer_addr;
  logic [VA_W-1:0]  inner_addr;

  assign outer_idx = vaddr[VA_W-1 -: IDX_W];
  assign inner_idx = vaddr[OFF_W +: IDX_W];

  // Outer entry: table root plus scaled index (full add, root is arbitrary).
  assign outer_addr = root + (VA_W'(outer_idx) << PTE_LG);

  // Inner entry: page named by the outer entry; the scaled index fits in
  // the page, so the add reduces to a concatenation in hardware.
  assign inner_addr = {outer_frame, {OFF_W{1'b0}}} + (VA_W'(inner_idx) << PTE_LG);

  assign tbl_addr = sel_inner ? inner_addr : outer_addr;

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
  parameter int unsigned PTE_W   = ptw_pkg::PTW_PTE_W,
  parameter int unsigned FRAME_W = ptw_pkg::PTW_FRAME_W
) (
  input  logic [PTE_W-1:0]   entry,
  input  logic               is_leaf,
  input  logic               is_write,
  output logic [FRAME_W-1:0] frame,
  output logic               bad
);

  localparam int unsigned VLD_BIT = PTE_W - 1;
  localparam int unsigned WR_BIT  = PTE_W - 2;

  logic present;
  logic no_write;

  assign present  = entry[VLD_BIT];
  // Write permission only matters on the leaf.
  assign no_write = is_leaf & is_write & ~entry[WR_BIT];
  assign bad      = ~present | no_write;
  assign frame    = entry[FRAME_W-1:0];

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        pte_bad,
  output walk_state_e state_q,
  output logic        accept,
  output logic        outer_take,
  output logic        leaf_take,
  output logic        fault_take
);

  walk_state_e state_d;

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    outer_take = 1'b0;
    leaf_take  = 1'b0;
    fault_take = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_READ_L1;
        end
      end
      ST_READ_L1: begin
        if (mem_req_ready) state_d = ST_WAIT_L1;
      end
      ST_WAIT_L1: begin
        if (mem_rsp_valid) begin
          if (pte_bad) begin
            fault_take = 1'b1;
            state_d    = ST_FAULT;
          end else begin
            outer_take = 1'b1;
            state_d    = ST_READ_L2;
          end
        end
      end
      ST_READ_L2: begin
        if (mem_req_ready) state_d = ST_WAIT_L2;
      end
      ST_WAIT_L2: begin
        if (mem_rsp_valid) begin
          if (pte_bad) begin
            fault_take = 1'b1;
            state_d    = ST_FAULT;
          end else begin
            leaf_take = 1'b1;
            state_d   = ST_DONE;
          end
        end
      end
      ST_DONE, ST_FAULT: state_d = ST_IDLE;
      default:           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R6: the inner read is only entered from a valid outer response.
  p_inner_after_outer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ_L2) |->
      ($past(state_q) == ST_WAIT_L1 || $past(state_q) == ST_READ_L2));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W   = PTW_VA_W,
  parameter int unsigned OFF_W  = PTW_OFF_W,
  parameter int unsigned IDX_W  = PTW_IDX_W,
  parameter int unsigned PTE_W  = PTW_PTE_W,
  parameter int unsigned PTE_LG = PTW_PTE_LG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic [VA_W-1:0] root_base,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [1:0]      rsp_fault_level,
  output logic [VA_W-1:0] rsp_paddr
);

  localparam int unsigned FRAME_W = VA_W - OFF_W;

  walk_state_e       state_q;
  logic              accept;
  logic              outer_take;
  logic              leaf_take;
  logic              fault_take;
  logic              pte_bad;
  logic [FRAME_W-1:0] pte_frame;
  logic              in_inner;
  logic              in_wait;

  logic [VA_W-1:0]    vaddr_q;
  logic [VA_W-1:0]    root_q;
  logic               write_q;
  logic [FRAME_W-1:0] outer_frame_q;
  logic [VA_W-1:0]    paddr_q;
  logic [1:0]         fault_lvl_q;

  ptw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_bad       (pte_bad),
    .state_q       (state_q),
    .accept        (accept),
    .outer_take    (outer_take),
    .leaf_take     (leaf_take),
    .fault_take    (fault_take)
  );

  assign in_inner = (state_q == ST_READ_L2) || (state_q == ST_WAIT_L2);
  assign in_wait  = (state_q == ST_WAIT_L1) || (state_q == ST_WAIT_L2);

  ptw_addr_gen #(
    .VA_W   (VA_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .PTE_LG (PTE_LG)
  ) u_addr (
    .vaddr       (vaddr_q),
    .root        (root_q),
    .outer_frame (outer_frame_q),
    .sel_inner   (in_inner),
    .tbl_addr    (mem_req_addr)
  );

  ptw_pte_check #(
    .PTE_W   (PTE_W),
    .FRAME_W (FRAME_W)
  ) u_pte (
    .entry    (mem_rsp_data),
    .is_leaf  (state_q == ST_WAIT_L2),
    .is_write (write_q),
    .frame    (pte_frame),
    .bad      (pte_bad)
  );

  // Request capture, enabled on acceptance only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      root_q  <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      vaddr_q <= req_vaddr;
      root_q  <= root_base;
      write_q <= req_write;
    end
  end

  // Outer entry frame, enabled on a valid outer response.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outer_frame_q <= '0;
    else if (outer_take) outer_frame_q <= pte_frame;
  end

  // Result registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         paddr_q <= '0;
    else if (leaf_take) paddr_q <= {pte_frame, vaddr_q[OFF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_lvl_q <= LVL_NONE;
    end else if (accept) begin
      fault_lvl_q <= LVL_NONE;
    end else if (fault_take) begin
      fault_lvl_q <= in_inner ? LVL_INNER : LVL_OUTER;
    end
  end

  assign req_ready       = (state_q == ST_IDLE);
  assign mem_req_valid   = (state_q == ST_READ_L1) || (state_q == ST_READ_L2);
  assign rsp_valid       = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault       = (state_q == ST_FAULT);
  assign rsp_fault_level = (state_q == ST_FAULT) ? fault_lvl_q : LVL_NONE;
  assign rsp_paddr       = (state_q == ST_DONE) ? paddr_q : '0;

  // R4: a pending table read keeps its address until taken.
  p_read_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2: latched request cannot change while the walker is busy.
  p_busy_ignores_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(vaddr_q));

  // R9: the offset passes through untouched.
  p_offset_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

  // R5: a fault always names a real level.
  p_fault_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_fault_level == LVL_OUTER || rsp_fault_level == LVL_INNER));

  // R10: the result is a single-cycle pulse followed by readiness.
  p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R11: no response is consumed outside a wait state.
  p_idle_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> req_ready);

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic [31:0] root_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_fault_level;
  logic [31:0] rsp_paddr;

  pt_walker i_pt_walker (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vaddr       (req_vaddr),
    .req_write       (req_write),
    .root_base       (root_base),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_data    (mem_rsp_data),
    .rsp_valid       (rsp_valid),
    .rsp_fault       (rsp_fault),
    .rsp_fault_level (rsp_fault_level),
    .rsp_paddr       (rsp_paddr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd_mem(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Reference model state: phase 0 idle, 1 outer read, 2 outer wait,
  // 3 inner read, 4 inner wait, 5 result.
  int          ph;
  logic [31:0] m_va, m_root, m_pa;
  logic        m_wr, m_fault;
  logic [19:0] m_frame;
  logic [1:0]  m_lvl;
  int          stall_cfg, lat_cfg, stall_left, pend_cnt;
  bit          pend, stray;
  logic [31:0] pend_addr;

  function automatic logic [31:0] model_addr();
    if (ph == 1) return m_root + {20'h0, m_va[31:22], 2'b00};
    return {m_frame, m_va[21:12], 2'b00};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; pend = 0; pend_cnt = 0; stall_left = 0;
    end else begin
      if (mem_rsp_valid && !stray) pend = 0;
      if (pend && pend_cnt > 0) pend_cnt--;
      case (ph)
        0: if (req_valid) begin
             m_va = req_vaddr; m_wr = req_write; m_root = root_base;
             m_fault = 0; m_lvl = 0; m_pa = 0;
             stall_left = stall_cfg; ph = 1;
           end
        1, 3: if (mem_req_ready) begin
             pend = 1; pend_addr = model_addr(); pend_cnt = lat_cfg; ph = ph + 1;
           end else stall_left--;
        2: if (mem_rsp_valid) begin
             if (!mem_rsp_data[31]) begin m_fault = 1; m_lvl = 1; ph = 5; end
             else begin m_frame = mem_rsp_data[19:0]; stall_left = stall_cfg; ph = 3; end
           end
        4: if (mem_rsp_valid) begin
             if (!mem_rsp_data[31] || (m_wr && !mem_rsp_data[30])) begin
               m_fault = 1; m_lvl = 2; ph = 5;
             end else begin
               m_pa = {mem_rsp_data[19:0], m_va[11:0]}; ph = 5;
             end
           end
        default: ph = 0;
      endcase
    end
  end

  // Memory side drive.
  always @(negedge clk) begin
    mem_req_ready = (stall_left <= 0);
    if (stray) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hFFFF_FFFF;
    end else begin
      mem_rsp_valid = pend && (pend_cnt == 0);
      mem_rsp_data  = mem_rsp_valid ? rd_mem(pend_addr) : 32'h0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 req_ready", {31'h0, req_ready}, {31'h0, ph == 0});
      chk("R4 mem_req_valid", {31'h0, mem_req_valid}, {31'h0, (ph == 1 || ph == 3)});
      if (ph == 1) chk("R3 outer address", mem_req_addr, model_addr());
      if (ph == 3) chk("R6 inner address", mem_req_addr, model_addr());
      chk("R10 rsp_valid", {31'h0, rsp_valid}, {31'h0, ph == 5});
      if (ph == 5) begin
        if (m_lvl == 1)     chk("R5 fault", {29'h0, rsp_fault, rsp_fault_level}, {29'h0, m_fault, m_lvl});
        else if (m_wr)      chk("R8 fault", {29'h0, rsp_fault, rsp_fault_level}, {29'h0, m_fault, m_lvl});
        else                chk("R7 fault", {29'h0, rsp_fault, rsp_fault_level}, {29'h0, m_fault, m_lvl});
        chk("R9 paddr", rsp_paddr, m_pa);
      end
    end
  end

  task automatic walk(logic [31:0] va, logic wr, bit poke, int stall, int lat);
    while (ph != 0) @(negedge clk);
    stall_cfg = stall; lat_cfg = lat;
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    if (poke) begin
      // R2: a different request held during the walk must be ignored.
      req_vaddr = ~va; req_write = ~wr;
      while (ph != 5) @(negedge clk);
    end
    req_valid = 1'b0;
    while (ph != 0) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    root_base = 32'h0010_0000; stray = 0; stall_cfg = 0; lat_cfg = 0;
    mem[32'h0010_000C] = 32'h8000_0200; // outer 3, write bit clear (R6: ignored)
    mem[32'h0020_0014] = 32'hC001_2345; // inner 5, writable
    mem[32'h0020_0018] = 32'h8005_4321; // inner 6, read-only
    mem[32'h0010_0FFC] = 32'h8000_03FF; // outer 1023
    mem[32'h003F_FFFC] = 32'hC00F_FFFF; // inner 1023
    mem[32'h0010_0000] = 32'h8000_0001; // outer 0
    mem[32'h0000_1000] = 32'h8000_0000; // inner 0, frame 0
    mem[32'h0034_000C] = 32'h8000_0201; // second root, outer 3
    mem[32'h0020_1014] = 32'hC000_0777;

    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(32'h00C0_5ABC, 1'b0, 0, 0, 0); // R9 basic read, R6 outer rw ignored
    walk(32'h00C0_5ABC, 1'b1, 0, 2, 3); // R9 write to writable leaf, R4 stalls
    walk(32'h00C0_6123, 1'b1, 0, 1, 0); // R8 write to read-only leaf faults
    walk(32'h00C0_6123, 1'b0, 0, 0, 1); // R8 read of read-only leaf succeeds
    walk(32'h00C0_7000, 1'b0, 0, 0, 0); // R7 invalid leaf
    walk(32'h0100_0000, 1'b0, 0, 3, 2); // R5 invalid outer, no second read
    walk(32'hFFFF_FFFF, 1'b0, 0, 0, 0); // R9 top boundary
    walk(32'h0000_0123, 1'b1, 1, 1, 1); // R2 busy request ignored
    // R11: stray response while idle has no effect
    stray = 1; @(negedge clk); @(negedge clk); stray = 0;
    walk(32'h00C0_5ABC, 1'b0, 0, 0, 0);
    // R3: root sampled at acceptance; change it mid-walk
    while (ph != 0) @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h00C0_5ABC; req_write = 1'b0;
    stall_cfg = 2; lat_cfg = 1;
    @(negedge clk);
    req_valid = 1'b0; root_base = 32'h0034_0000;
    while (ph != 0) @(negedge clk);
    walk(32'h00C0_5ABC, 1'b0, 0, 0, 0); // R3 new root now used
    walk(32'h00C0_5ABC, 1'b0, 0, 0, 2); // R10 back-to-back

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule